// File: doc/BRIEF.md
# Banked Integer Register File

This block is a 32-entry, 64-bit integer register file with two combinational read ports and one synchronous write port. Eight of its indices (8, 9, 10, 11, 12, 13, 14 and 25) have a second, alternate copy. That copy is what the pipeline sees while the processor runs privileged handler code. Every other index names one storage location that both modes share. Index 31 is a hard-wired zero.

A bank-select flag steers the banked indices to one copy or the other. No data moves when the banks change. A one-cycle request to enter the alternate bank or to leave it flips the flag at the next clock edge. A request that would not change the flag is illegal: asking to enter while already inside, asking to leave while outside, or asking for both at once. Such a request leaves the flag alone and raises a sticky error output that only reset clears.

After reset the alternate bank is active, every register reads zero and the error output is low.

Top module: `shadow_regfile`

## Requirements
- R1: After reset `shadow_active` is 1, `swap_err` is 0, and every index reads zero on both read ports.
- R2: A write with `wr_en` high stores `wr_data` at `wr_idx` on the rising edge. Both read ports are combinational and show the new value in the cycle after that edge.
- R3: Index 31 always reads zero, and writes to it have no effect.
- R4: The banked indices are 8 to 14 and 25. While `shadow_active` is 1 they read and write the alternate copy. While it is 0 they use the main copy.
- R5: All indices other than 8 to 14, 25 and 31 address one shared location, whatever the state of `shadow_active`.
- R6: With `enter_shadow`=1 and `leave_shadow`=0 while `shadow_active`=0, `shadow_active` is 1 after the next edge. With `leave_shadow`=1 and `enter_shadow`=0 while `shadow_active`=1, it is 0 after the next edge.
- R7: An illegal request (enter while active, leave while inactive, or both inputs high together) leaves `shadow_active` unchanged and sets `swap_err` at the next edge. A write in that cycle still takes effect.
- R8: Once set, `swap_err` stays high through any further traffic until reset.
- R9: When a write and a bank change occur in the same cycle, the write lands in the bank that was active before the change.
- R10: Changing banks alters the stored contents of neither copy. It changes only which copy the banked indices show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_data | input | 64 | Write data |
| enter_shadow | input | 1 | Request to switch to the alternate bank |
| leave_shadow | input | 1 | Request to switch back to the main bank |
| shadow_active | output | 1 | 1 while the alternate bank is selected |
| swap_err | output | 1 | Sticky illegal-request flag |

## Verification
A register write and a bank change can fall in the same clock cycle, and the write must go to the bank selected before the edge. The bench provokes this in both directions. It writes a banked index while entering the alternate bank, and another while leaving it. It also pairs a write with an illegal request. Afterwards it reads all 32 indices in both bank states and compares each value with a bench model that applies the write under the old bank state before updating that state.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  typedef enum logic {
    BANK_MAIN = 1'b0,
    BANK_ALT  = 1'b1
  } bank_e;

  // Number of set bits in a bank mask; sizes the alternate storage.
  function automatic int unsigned mask_count(input logic [63:0] mask);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (mask[i]) n++;
    end
    return n;
  endfunction

  // Alternate-storage slot of a banked index: banked indices below it.
  function automatic int unsigned slot_of(input logic [63:0] mask,
                                          input int unsigned idx);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (mask[i] && (i < idx)) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/shreg_bank_ctrl.sv
module shreg_bank_ctrl
  import shreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic leave_req,
  output logic alt_sel,
  output logic err_flag
);

  bank_e bank_q, bank_d;
  logic  err_q, err_d;
  logic  illegal;
  logic  upd_en;

  always_comb begin
    illegal = (enter_req && leave_req)
            || (enter_req && (bank_q == BANK_ALT))
            || (leave_req && (bank_q == BANK_MAIN));
    upd_en  = enter_req || leave_req;
    bank_d  = bank_q;
    if (!illegal) begin
      if (enter_req) bank_d = BANK_ALT;
      if (leave_req) bank_d = BANK_MAIN;
    end
    err_d = err_q || illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= BANK_ALT;
      err_q  <= 1'b0;
    end else if (upd_en) begin
      bank_q <= bank_d;
      err_q  <= err_d;
    end
  end

  assign alt_sel  = (bank_q == BANK_ALT);
  assign err_flag = err_q;

  assert_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && !leave_req && !alt_sel) |=> alt_sel);

  assert_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (leave_req && !enter_req && alt_sel) |=> !alt_sel);

  assert_reenter_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && alt_sel) |=> (alt_sel && err_flag));

  assert_releave_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (leave_req && !alt_sel) |=> (!alt_sel && err_flag));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

endmodule

// File: rtl/shreg_storage.sv
module shreg_storage
  import shreg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned DATA_W    = 64,
  parameter logic [NUM_REGS-1:0] BANK_MASK = 32'h0200_7F00,
  parameter int unsigned IDX_W     = $clog2(NUM_REGS),
  parameter int unsigned NUM_ALT   = mask_count(64'(BANK_MASK))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alt_sel,
  output logic [DATA_W-1:0] main_q [NUM_REGS],
  output logic [DATA_W-1:0] alt_q  [NUM_ALT]
);

  localparam int unsigned ZERO_IDX = NUM_REGS - 1;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_main
    if (g == ZERO_IDX) begin : g_zero
      assign main_q[g] = '0;
    end else begin : g_cell
      localparam bit BANKED = BANK_MASK[g];
      logic              we;
      logic [DATA_W-1:0] q;
      always_comb begin
        we = wr_en && (wr_idx == IDX_W'(g)) && !(BANKED && alt_sel);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wr_data;
      end
      assign main_q[g] = q;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_alt
    if (BANK_MASK[g] && (g != ZERO_IDX)) begin : g_cell
      localparam int unsigned SLOT = slot_of(64'(BANK_MASK), g);
      logic              we;
      logic [DATA_W-1:0] q;
      always_comb begin
        we = wr_en && alt_sel && (wr_idx == IDX_W'(g));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wr_data;
      end
      assign alt_q[SLOT] = q;
    end
  end

endmodule

// File: rtl/shreg_read_port.sv
module shreg_read_port
  import shreg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned DATA_W    = 64,
  parameter logic [NUM_REGS-1:0] BANK_MASK = 32'h0200_7F00,
  parameter int unsigned IDX_W     = $clog2(NUM_REGS),
  parameter int unsigned NUM_ALT   = mask_count(64'(BANK_MASK))
) (
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              alt_sel,
  input  logic [DATA_W-1:0] main_q [NUM_REGS],
  input  logic [DATA_W-1:0] alt_q  [NUM_ALT],
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned ZERO_IDX = NUM_REGS - 1;
  localparam int unsigned SLOT_W   = (NUM_ALT > 1) ? $clog2(NUM_ALT) : 1;

  logic [SLOT_W-1:0] slot_lut [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lut
    assign slot_lut[g] = SLOT_W'(slot_of(64'(BANK_MASK), g));
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx != IDX_W'(ZERO_IDX)) begin
      if (alt_sel && BANK_MASK[rd_idx]) rd_data = alt_q[slot_lut[rd_idx]];
      else                              rd_data = main_q[rd_idx];
    end
  end

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import shreg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned DATA_W    = 64,
  parameter logic [NUM_REGS-1:0] BANK_MASK = 32'h0200_7F00,
  parameter int unsigned IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              enter_shadow,
  input  logic              leave_shadow,
  output logic              shadow_active,
  output logic              swap_err
);

  localparam int unsigned NUM_ALT  = mask_count(64'(BANK_MASK));
  localparam int unsigned ZERO_IDX = NUM_REGS - 1;

  logic              alt_sel;
  logic [DATA_W-1:0] main_q [NUM_REGS];
  logic [DATA_W-1:0] alt_q  [NUM_ALT];
  logic [IDX_W-1:0]  rd_idx [2];
  logic [DATA_W-1:0] rd_dat [2];

  shreg_bank_ctrl u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_req (enter_shadow),
    .leave_req (leave_shadow),
    .alt_sel   (alt_sel),
    .err_flag  (swap_err)
  );

  shreg_storage #(
    .NUM_REGS (NUM_REGS), .DATA_W (DATA_W), .BANK_MASK (BANK_MASK),
    .IDX_W (IDX_W), .NUM_ALT (NUM_ALT)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .alt_sel (alt_sel),
    .main_q  (main_q),
    .alt_q   (alt_q)
  );

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    shreg_read_port #(
      .NUM_REGS (NUM_REGS), .DATA_W (DATA_W), .BANK_MASK (BANK_MASK),
      .IDX_W (IDX_W), .NUM_ALT (NUM_ALT)
    ) u_port (
      .rd_idx  (rd_idx[p]),
      .alt_sel (alt_sel),
      .main_q  (main_q),
      .alt_q   (alt_q),
      .rd_data (rd_dat[p])
    );
  end

  assign rd_a_data     = rd_dat[0];
  assign rd_b_data     = rd_dat[1];
  assign shadow_active = alt_sel;

  assert_zero_read_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == IDX_W'(ZERO_IDX)) |-> (rd_a_data == '0));

  assert_zero_read_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == IDX_W'(ZERO_IDX)) |-> (rd_b_data == '0));

endmodule

// File: tb/shadow_regfile_tb.sv
module shadow_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, enter_shadow = 1'b0, leave_shadow = 1'b0;
  logic        shadow_active, swap_err;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] m_main [32];
  logic [63:0] m_alt  [32];
  bit          m_mode;
  bit          m_err;

  always #5 clk = ~clk;

  shadow_regfile u_dut (
    .clk (clk), .rst_n (rst_n),
    .rd_a_idx (rd_a_idx), .rd_a_data (rd_a_data),
    .rd_b_idx (rd_b_idx), .rd_b_data (rd_b_data),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
    .enter_shadow (enter_shadow), .leave_shadow (leave_shadow),
    .shadow_active (shadow_active), .swap_err (swap_err)
  );

  function automatic bit banked(input int i);
    return ((i >= 8) && (i <= 14)) || (i == 25);
  endfunction

  function automatic logic [63:0] expv(input int i);
    if (i == 31) return 64'd0;
    if (banked(i) && m_mode) return m_alt[i];
    return m_main[i];
  endfunction

  function automatic logic [63:0] pat(input int i, input int k);
    return {32'(i * 32'h0101_0101 + k), 32'(k * 32'h9E37_79B9) ^ 32'(i)};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      m_main[i] = '0;
      m_alt[i]  = '0;
    end
    m_mode = 1'b1;
    m_err  = 1'b0;
  endtask

  task automatic check64(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    check64(req, {63'd0, shadow_active}, {63'd0, m_mode});
    check64(req, {63'd0, swap_err}, {63'd0, m_err});
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i);
      rd_b_idx = 5'(31 - i);
      #1;
      check64(req, rd_a_data, expv(i));
      check64(req, rd_b_data, expv(31 - i));
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic cycle(input bit we, input int widx, input logic [63:0] wd,
                       input bit en, input bit lv);
    wr_en = we; wr_idx = 5'(widx); wr_data = wd;
    enter_shadow = en; leave_shadow = lv;
    @(posedge clk);
    if (we && (widx != 31)) begin
      if (banked(widx) && m_mode) m_alt[widx] = wd;
      else                        m_main[widx] = wd;
    end
    if (en || lv) begin
      if ((en && lv) || (en && m_mode) || (lv && !m_mode)) m_err = 1'b1;
      else m_mode = en;
    end
    @(negedge clk);
    wr_en = 1'b0; enter_shadow = 1'b0; leave_shadow = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    check_flags("R1");
    check_all("R1");

    // R2/R3/R4: fill every index in the alternate bank state
    for (int i = 0; i < 32; i++) cycle(1, i, pat(i, 1), 0, 0);
    check_all("R2");
    rd_a_idx = 5'd31; #1;
    check64("R3", rd_a_data, 64'd0);

    // R6/R10: leave, banked indices now show the untouched main copy
    cycle(0, 0, '0, 0, 1);
    check_flags("R6");
    check_all("R10");

    // R5: refill in main state; shared entries overwritten
    for (int i = 0; i < 32; i++) cycle(1, i, pat(i, 2), 0, 0);
    check_all("R5");

    // R4/R6: enter again, alternate values reappear
    cycle(0, 0, '0, 1, 0);
    check_flags("R6");
    check_all("R4");
    cycle(0, 0, '0, 0, 1);
    check_all("R4");

    // R9: write together with a bank change, both directions
    cycle(1, 9, pat(9, 3), 1, 0);
    check_flags("R9");
    check_all("R9");
    cycle(1, 25, pat(25, 4), 0, 1);
    check_all("R9");
    cycle(1, 3, pat(3, 5), 1, 0);
    check_all("R9");
    cycle(1, 14, pat(14, 6), 0, 1);
    check_all("R9");
    cycle(0, 0, '0, 1, 0);
    check_all("R9");

    // R7: illegal enter while active, with a write to a banked index
    cycle(1, 10, pat(10, 7), 1, 0);
    check_flags("R7");
    check_all("R7");
    // R8: legal traffic keeps the error set
    cycle(0, 0, '0, 0, 1);
    check_flags("R8");
    cycle(1, 12, pat(12, 8), 0, 1);
    check_flags("R7");
    check_all("R7");
    cycle(1, 8, pat(8, 9), 1, 1);
    check_flags("R7");
    check_all("R7");
    cycle(0, 0, '0, 1, 0);
    check_flags("R8");
    check_all("R8");

    // R8/R1: reset clears the error and contents
    do_reset();
    check_flags("R8");
    check_all("R1");

    // R6/R9 in a fresh run with both ports on banked indices
    cycle(1, 13, pat(13, 10), 0, 1);
    check_all("R9");
    cycle(1, 13, pat(13, 11), 0, 0);
    check_all("R2");
    cycle(0, 0, '0, 1, 0);
    check_all("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule